// File: doc/BRIEF.md
# GPIO Group Interrupt Controller

This block watches up to four 32-bit general-purpose input ports and turns a few chosen pins into interrupt sources. It has eight shared interrupt slots, not one interrupt per pin. Slot g can only serve pins whose bit index within their port is congruent to g modulo 8. A 4-bit selector per slot picks which of its sixteen candidate pins feeds it. Each slot has its own 3-bit trigger mode: off, level high, level low, always asserted, rising edge, falling edge or either edge. Each slot also has a mask bit and a write-one-to-clear acknowledge.

Every pin input passes through a two-flop synchronizer before it reaches the slot logic. Edge events are latched until software acknowledges them. Level conditions follow the synchronized pin and are not latched. A word-wide register bus gives access to the trigger modes, the selectors, the mask and the acknowledge. It also returns the raw and the masked slot status. A single registered interrupt line is high whenever any unmasked slot is active.

Top module: `gpio_group_irq`

## Requirements
- R1: After a synchronous reset, the trigger-mode, selector and mask registers read zero, the raw and masked status read zero, and `irq_o` is low.
- R2: The register map uses byte addresses: 120 trigger modes, 124 selectors, 128 mask, 132 acknowledge, 136 raw status, 140 masked status. Only the low 24 bits of the trigger-mode register and the low 8 bits of the mask are kept. The acknowledge address, unimplemented bits and all other addresses read zero. Writes to other addresses change nothing.
- R3: Selector field g occupies bits [4g+3:4g]. A field value v makes slot g watch port v[3:2] (port n starts at bit 32n of `pins_i`), pin index 8*v[1:0]+g, so the slot watches `pins_i` bit 32*(v div 4) + 8*(v mod 4) + g. Pins that are not selected have no effect on the slot.
- R4: Trigger-mode field g occupies bits [3g+2:3g]. Code 1 makes the slot status equal to the synchronized pin, code 2 makes it equal to the inverted pin, and code 3 holds it at 1. These level codes are not latched.
- R5: Code 5 latches a rising edge, code 6 latches a falling edge, and code 7 latches either edge. The latched status stays set until it is acknowledged and is cleared whenever the slot is not in an edge code.
- R6: Codes 0 and 4 keep the slot status at 0 whatever the pin does.
- R7: Writing 1 to bit g at the acknowledge address clears the latched status of slot g. Bits written as 0 leave their slots unchanged.
- R8: An edge event that arrives in the same clock cycle as an acknowledge of its slot leaves the status set.
- R9: The masked status equals the raw status ANDed with the mask. A mask bit of 1 enables its slot.
- R10: `irq_o` is a register that holds the OR of the masked status bits from the previous cycle.
- R11: A change on a pin reaches the raw status of a level-mode slot after exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PORTS*PORT_W (128) | Asynchronous port inputs; port n occupies bits [32n+31:32n] |
| bus_wen | input | 1 | Register write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W (8) | Register byte address for reads and writes |
| bus_wdata | input | DATA_W (32) | Register write data |
| bus_rdata | output | DATA_W (32) | Register read data, combinational from the address |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with its default parameters: four 32-bit ports and eight slots, each slot with sixteen candidates. At this size, every slot and selector pair can be swept, so all 128 pins are routed and their unselected neighbours are rejected. The trigger sweep runs all eight mode codes, including the reserved one, through a low-high-low pin sequence with acknowledges between the steps. Cycle-exact stimulus covers the synchronizer delay, the interrupt register and the coincidence of an edge with an acknowledge.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

    typedef enum logic [2:0] {
        TRIG_OFF  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_ONE  = 3'd3,
        TRIG_RSV  = 3'd4,
        TRIG_RISE = 3'd5,
        TRIG_FALL = 3'd6,
        TRIG_BOTH = 3'd7
    } trig_e;

    localparam int TRIG_W = 3;

    localparam int OFS_CFG    = 120;
    localparam int OFS_SEL    = 124;
    localparam int OFS_MASK   = 128;
    localparam int OFS_ACK    = 132;
    localparam int OFS_RAW    = 136;
    localparam int OFS_MASKED = 140;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic trig_is_edge(trig_e m);
        return (m == TRIG_RISE) || (m == TRIG_FALL) || (m == TRIG_BOTH);
    endfunction

    function automatic logic trig_level(trig_e m, logic pin);
        logic r;
        case (m)
            TRIG_HIGH: r = pin;
            TRIG_LOW:  r = ~pin;
            TRIG_ONE:  r = 1'b1;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic trig_event(trig_e m, edge_t e);
        logic r;
        case (m)
            TRIG_RISE: r = e.rise;
            TRIG_FALL: r = e.fall;
            TRIG_BOTH: r = e.rise | e.fall;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;

    // R11: second stage follows the first one cycle later
    a_r11_two_stage: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (s2_q == $past(s1_q)));

endmodule

// File: rtl/gpirq_slot.sv
module gpirq_slot
    import gpirq_pkg::*;
#(
    parameter int NCAND = 16,
    parameter int SEL_W = $clog2(NCAND)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCAND-1:0] cand_i,
    input  logic [SEL_W-1:0] sel_i,
    input  trig_e            mode_i,
    input  logic             ack_i,
    output logic             raw_o
);
    logic  pin;
    logic  prev_q;
    logic  st_q;
    logic  is_edge;
    logic  evt;
    edge_t edges;

    always_comb begin
        pin        = cand_i[sel_i];
        edges.rise = pin & ~prev_q;
        edges.fall = ~pin & prev_q;
        is_edge    = trig_is_edge(mode_i);
        evt        = trig_event(mode_i, edges);
        raw_o      = is_edge ? st_q : trig_level(mode_i, pin);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            st_q   <= 1'b0;
        end else begin
            prev_q <= pin;
            if (is_edge) st_q <= (st_q & ~ack_i) | evt;
            else         st_q <= 1'b0;
        end
    end

    // R5: a latched edge survives until acknowledged
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (is_edge && st_q && !ack_i) |=> st_q);

    // R5: leaving the edge codes drops the latch
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        !is_edge |=> !st_q);

    // R8: an edge wins against a coincident acknowledge
    a_r8_race: assert property (@(posedge clk) disable iff (rst)
        (is_edge && evt && ack_i) |=> st_q);

endmodule

// File: rtl/gpirq_regs.sv
module gpirq_regs
    import gpirq_pkg::*;
#(
    parameter int NUM_GRP = 8,
    parameter int SEL_W   = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wen_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic [NUM_GRP-1:0]         raw_i,
    output logic [DATA_W-1:0]          rdata_o,
    output logic [TRIG_W*NUM_GRP-1:0]  cfg_o,
    output logic [SEL_W*NUM_GRP-1:0]   sel_o,
    output logic [NUM_GRP-1:0]         masked_o,
    output logic [NUM_GRP-1:0]         ack_o
);
    localparam int CFG_BITS = TRIG_W * NUM_GRP;
    localparam int SEL_BITS = SEL_W * NUM_GRP;
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_SEL    = ADDR_W'(OFS_SEL);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFS_ACK);
    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);

    logic [CFG_BITS-1:0] cfg_q;
    logic [SEL_BITS-1:0] sel_q;
    logic [NUM_GRP-1:0]  mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            sel_q  <= '0;
            mask_q <= '0;
        end else if (wen_i) begin
            if (addr_i == A_CFG)  cfg_q  <= wdata_i[CFG_BITS-1:0];
            if (addr_i == A_SEL)  sel_q  <= wdata_i[SEL_BITS-1:0];
            if (addr_i == A_MASK) mask_q <= wdata_i[NUM_GRP-1:0];
        end
    end

    always_comb begin
        ack_o    = (wen_i && addr_i == A_ACK) ? wdata_i[NUM_GRP-1:0] : '0;
        masked_o = raw_i & mask_q;
        rdata_o  = '0;
        if (addr_i == A_CFG)         rdata_o[CFG_BITS-1:0] = cfg_q;
        else if (addr_i == A_SEL)    rdata_o[SEL_BITS-1:0] = sel_q;
        else if (addr_i == A_MASK)   rdata_o[NUM_GRP-1:0]  = mask_q;
        else if (addr_i == A_RAW)    rdata_o[NUM_GRP-1:0]  = raw_i;
        else if (addr_i == A_MASKED) rdata_o[NUM_GRP-1:0]  = masked_o;
    end

    assign cfg_o = cfg_q;
    assign sel_o = sel_q;

    // R2: configuration only moves on a write to its own address
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !(wen_i && addr_i == A_CFG) |=> $stable(cfg_q));

    // R2: mask only moves on a write to its own address
    a_r2_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !(wen_i && addr_i == A_MASK) |=> $stable(mask_q));

endmodule

// File: rtl/gpio_group_irq.sv
module gpio_group_irq
    import gpirq_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 32,
    parameter int NUM_GRP   = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS*PORT_W-1:0] pins_i,
    input  logic                        bus_wen,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        irq_o
);
    localparam int PIN_N    = NUM_PORTS * PORT_W;
    localparam int PER_PORT = PORT_W / NUM_GRP;
    localparam int NCAND    = NUM_PORTS * PER_PORT;
    localparam int SEL_W    = $clog2(NCAND);

    logic [PIN_N-1:0]                 pin_s;
    logic [NUM_GRP-1:0][NCAND-1:0]    cand;
    logic [TRIG_W*NUM_GRP-1:0]        cfg;
    logic [SEL_W*NUM_GRP-1:0]         sel;
    logic [NUM_GRP-1:0]               raw;
    logic [NUM_GRP-1:0]               masked;
    logic [NUM_GRP-1:0]               ack;
    logic                             irq_q;

    gpirq_sync #(.W(PIN_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pins_i),
        .q_o (pin_s)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_slot
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            for (genvar i = 0; i < PER_PORT; i++) begin : g_cand
                assign cand[g][p*PER_PORT + i] = pin_s[p*PORT_W + i*NUM_GRP + g];
            end
        end

        gpirq_slot #(.NCAND(NCAND), .SEL_W(SEL_W)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .cand_i (cand[g]),
            .sel_i  (sel[g*SEL_W +: SEL_W]),
            .mode_i (trig_e'(cfg[g*TRIG_W +: TRIG_W])),
            .ack_i  (ack[g]),
            .raw_o  (raw[g])
        );
    end

    gpirq_regs #(
        .NUM_GRP (NUM_GRP),
        .SEL_W   (SEL_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wen_i    (bus_wen),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .raw_i    (raw),
        .rdata_o  (bus_rdata),
        .cfg_o    (cfg),
        .sel_o    (sel),
        .masked_o (masked),
        .ack_o    (ack)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |masked;
    end

    assign irq_o = irq_q;

    // R10: interrupt line is the masked status delayed by one register
    a_r10_irq_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_o == $past(|masked)));

    // R9: nothing masked means the line drops one cycle later
    a_r9_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        (masked == '0) |=> !irq_o);

endmodule

// File: tb/sim_gpio_group_irq.sv
module sim_gpio_group_irq;
    localparam logic [7:0] A_CFG = 8'd120, A_SEL = 8'd124, A_MASK = 8'd128;
    localparam logic [7:0] A_ACK = 8'd132, A_RAW = 8'd136, A_MSK = 8'd140;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] pins = '0;
    logic         wen = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         irq;
    int           total = 0;
    int           bad = 0;
    logic [31:0]  v;

    always #2 clk = ~clk;

    gpio_group_irq u0 (
        .clk (clk), .rst (rst), .pins_i (pins), .bus_wen (wen),
        .bus_addr (addr), .bus_wdata (wdata), .bus_rdata (rdata), .irq_o (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wen = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int pin_of(input int g, input int s);
        return (s / 4) * 32 + (s % 4) * 8 + g;
    endfunction

    function automatic logic lvl(input int m, input logic p);
        case (m)
            1: return p;
            2: return ~p;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(A_CFG, v);  chk("R1 cfg", v, 0);
        rd(A_SEL, v);  chk("R1 sel", v, 0);
        rd(A_MASK, v); chk("R1 mask", v, 0);
        rd(A_RAW, v);  chk("R1 raw", v, 0);
        rd(A_MSK, v);  chk("R1 masked", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 register map, reserved bits, unmapped addresses
        wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, v); chk("R2 cfg width", v, 32'h00FF_FFFF);
        wr(A_SEL, 32'h1234_5678); rd(A_SEL, v); chk("R2 sel", v, 32'h1234_5678);
        wr(A_MASK, 32'h0000_01A5); rd(A_MASK, v); chk("R2 mask width", v, 32'h0000_00A5);
        rd(A_ACK, v); chk("R2 ack reads zero", v, 0);
        wr(8'd0, 32'hFFFF_FFFF); rd(8'd0, v); chk("R2 unmapped read", v, 0);
        rd(A_CFG, v); chk("R2 unmapped write ignored", v, 32'h00FF_FFFF);
        wr(A_MASK, 0);

        // R3 route every slot/selector pair, reject the neighbour candidate
        for (int g = 0; g < 8; g++) begin
            wr(A_CFG, 32'd1 << (3 * g));
            for (int s = 0; s < 16; s++) begin
                wr(A_SEL, 32'(s) << (4 * g));
                pins = '0; pins[pin_of(g, s)] = 1'b1;
                idle(3);
                rd(A_RAW, v); chk($sformatf("R3 g%0d sel%0d", g, s), v, 32'd1 << g);
                pins = '0; pins[pin_of(g, (s + 1) % 16)] = 1'b1;
                idle(3);
                rd(A_RAW, v); chk($sformatf("R3 g%0d sel%0d other", g, s), v, 0);
            end
        end
        pins = '0;

        // R4 R5 R6 R9 R10 mode sweep on slot 3 with selector 5
        wr(A_SEL, 32'd5 << 12);
        wr(A_MASK, 32'h08);
        for (int m = 0; m < 8; m++) begin
            logic e;
            logic [3:0] ex;
            string tag;
            e = (m >= 5);
            tag = e ? "R5" : ((m == 0 || m == 4) ? "R6" : "R4");
            ex[0] = e ? 1'b0 : lvl(m, 1'b0);
            ex[1] = e ? (m != 6) : lvl(m, 1'b1);
            ex[2] = e ? 1'b0 : lvl(m, 1'b1);
            ex[3] = e ? (m != 5) : lvl(m, 1'b0);
            pins = '0;
            wr(A_CFG, 32'(m) << 9);
            idle(6); wr(A_ACK, 32'hFF); idle(2);
            for (int st = 0; st < 4; st++) begin
                if (st == 1) begin pins[pin_of(3, 5)] = 1'b1; idle(6); end
                if (st == 2) begin wr(A_ACK, 32'h08); idle(2); end
                if (st == 3) begin pins[pin_of(3, 5)] = 1'b0; idle(6); end
                rd(A_RAW, v);
                chk($sformatf("%s mode%0d step%0d", tag, m, st), v, {28'd0, ex[st], 3'd0});
                rd(A_MSK, v);
                chk($sformatf("R9 mode%0d step%0d", m, st), v, {28'd0, ex[st], 3'd0});
                chk($sformatf("R10 mode%0d step%0d", m, st), {31'd0, irq}, {31'd0, ex[st]});
            end
        end

        // R9 R10 mask gating with all slots always asserted
        wr(A_CFG, 32'h006D_B6DB);
        wr(A_MASK, 0); idle(2);
        rd(A_RAW, v); chk("R4 all set", v, 32'hFF);
        rd(A_MSK, v); chk("R9 masked none", v, 0);
        chk("R10 irq low", {31'd0, irq}, 0);
        wr(A_MASK, 32'hA5); idle(1);
        rd(A_MSK, v); chk("R9 masked A5", v, 32'hA5);
        chk("R10 irq high", {31'd0, irq}, 1);

        // R7 zero-write ignored, one bit at a time
        wr(A_MASK, 0); wr(A_SEL, 0); pins = '0;
        wr(A_CFG, 32'h0000_003F);
        idle(6); wr(A_ACK, 32'hFF); idle(2);
        pins[0] = 1'b1; pins[1] = 1'b1; idle(6);
        rd(A_RAW, v); chk("R5 both latched", v, 32'h03);
        wr(A_ACK, 32'h00); rd(A_RAW, v); chk("R7 zero ack", v, 32'h03);
        wr(A_ACK, 32'h01); rd(A_RAW, v); chk("R7 ack slot0", v, 32'h02);
        wr(A_ACK, 32'h02); rd(A_RAW, v); chk("R7 ack slot1", v, 32'h00);

        // R8 edge coincident with acknowledge on slot 2, rising
        pins = '0;
        wr(A_CFG, 32'd5 << 6);
        idle(6); wr(A_ACK, 32'hFF); idle(2);
        @(negedge clk); pins[2] = 1'b1;
        @(negedge clk);
        @(negedge clk); wen = 1'b1; addr = A_ACK; wdata = 32'h04;
        @(negedge clk); wen = 1'b0;
        rd(A_RAW, v); chk("R8 edge beats ack", v, 32'h04);
        wr(A_ACK, 32'h04); rd(A_RAW, v); chk("R7 later ack clears", v, 0);

        // R11 and R10 cycle timing, slot 0 level high
        pins = '0;
        wr(A_CFG, 32'd1); wr(A_MASK, 32'h01); idle(4);
        @(negedge clk); pins[0] = 1'b1; addr = A_RAW;
        @(negedge clk); #1 chk("R11 one edge", rdata, 0);
        chk("R10 irq one edge", {31'd0, irq}, 0);
        @(negedge clk); #1 chk("R11 two edges", rdata, 32'h01);
        chk("R10 irq two edges", {31'd0, irq}, 0);
        @(negedge clk); #1 chk("R10 irq three edges", {31'd0, irq}, 1);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        idle(2); rst = 1'b0;
        rd(A_CFG, v); chk("R1 cfg after reset", v, 0);
        rd(A_MASK, v); chk("R1 mask after reset", v, 0);
        chk("R1 irq after reset", {31'd0, irq}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule